// File: doc/BRIEF.md
# Disc Drive Task-File Register Front End

This block sits between a host register bus and the state logic of a disc drive. It holds the byte-wide parameter registers that the host fills in before it issues a drive command. These are a feature byte, a sector count, three logical-block-address bytes and a device-select byte. A command write ends the sequence. The drive logic receives the command code as a one-cycle strobe and reads the parameter bytes from dedicated outputs. Status, error and a disc-information byte come from the drive logic and are returned to the host on reads.

Some bus addresses mean one thing when written and another when read. The block decodes both directions. It also tracks a pending-interrupt flag. The drive logic raises the flag with a request pulse. The host lowers it either by reading the primary status or by issuing a command that is accepted. Reading the alternate status leaves the flag alone. The interrupt line to the host is masked by a disable bit in the last device-control byte written. While the drive logic holds the write-permission input low, the parameter and command registers accept no host writes.

Top module: `drive_taskfile`

## Requirements
- R1: While reset is asserted and directly after it is released, all six parameter registers, the pending flag, the device-control value, the command code and both strobes are zero.
- R2: A permitted write to a parameter address stores only bits [7:0] of the bus data. The addresses are 1 for feature, 2 for count, 3 for address byte 0, 4 for address byte 1, 5 for address byte 2 and 6 for device. The new value is visible on the matching output one clock after the write.
- R3: While `regs_wr_ok` is low, writes to addresses 1 to 7 change no parameter register, emit no command strobe and do not clear the pending flag. Writes to addresses 8 and above are always ignored.
- R4: A permitted write to address 7 raises `cmd_strobe` for exactly the next cycle. In that cycle `cmd_code` holds bits [7:0] of the written data, and it keeps that value until the next accepted command.
- R5: An accepted command write clears the pending flag.
- R6: A read of address 1 returns `drv_error`. It does not return the stored feature byte.
- R7: A read of address 7 returns `drv_status` and clears the pending flag.
- R8: A read of address 0 returns `drv_status` and leaves the pending flag unchanged.
- R9: A write to address 0 is taken whatever `regs_wr_ok` is. It pulses `devctl_strobe` for one cycle, updates `devctl_value` with bits [7:0] and changes no parameter register.
- R10: Reads of addresses 2, 4, 5 and 6 return the stored count, address byte 1, address byte 2 and device bytes. A read of address 3 returns `disc_info`. Reads of unmapped addresses, and bus data whenever `bus_rd` is low, return zero. Read data is combinational, and all upper bits are zero.
- R11: An `irq_req` pulse sets the pending flag one clock later. If a set and a clear arrive in the same cycle, the flag is set.
- R12: `irq_out` equals the pending flag ANDed with the inverse of bit 1 of `devctl_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write request this cycle |
| bus_rd | input | 1 | Host read request this cycle |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data; only [7:0] is used |
| bus_rdata | output | DATA_W | Combinational read data |
| regs_wr_ok | input | 1 | Drive logic permits parameter and command writes |
| irq_req | input | 1 | One-cycle interrupt request from drive logic |
| drv_status | input | 8 | Status byte for reads of addresses 0 and 7 |
| drv_error | input | 8 | Error byte for reads of address 1 |
| disc_info | input | 8 | Byte returned by reads of address 3 |
| feature_q | output | 8 | Stored feature byte |
| count_q | output | 8 | Stored sector count |
| lba0_q | output | 8 | Stored address byte 0 |
| lba1_q | output | 8 | Stored address byte 1 |
| lba2_q | output | 8 | Stored address byte 2 |
| device_q | output | 8 | Stored device-select byte |
| cmd_strobe | output | 1 | One-cycle pulse for an accepted command |
| cmd_code | output | 8 | Last accepted command code |
| devctl_strobe | output | 1 | One-cycle pulse for a device-control write |
| devctl_value | output | 8 | Last device-control byte |
| irq_pending | output | 1 | Pending-interrupt flag |
| irq_out | output | 1 | Interrupt to host after masking |

## Verification
The bench builds the block with the default 32-bit data bus and a 4-bit address. The wider data bus lets writes carry junk in bits [31:8], which shows that only the low byte is kept and that read data is zero-extended. The 4-bit address reaches the unmapped addresses 8 to 15, so the bench can check that writes there are ignored and reads there return zero. Directed sequences are followed by a long random run that toggles the permission input, interrupt requests and address collisions. This run reaches same-cycle set-and-clear and masked interrupts many times.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int TF_BYTE_W = 8;
  localparam int TF_NREG   = 6;
  localparam int TF_SLOT_W = 3;
  localparam int TF_IRQ_OFF_BIT = 1;

  typedef enum logic [TF_SLOT_W-1:0] {
    SLOT_CTL  = 3'd0,
    SLOT_FEAT = 3'd1,
    SLOT_CNT  = 3'd2,
    SLOT_LBA0 = 3'd3,
    SLOT_LBA1 = 3'd4,
    SLOT_LBA2 = 3'd5,
    SLOT_DEV  = 3'd6,
    SLOT_CMD  = 3'd7
  } tf_slot_e;

  // bank index of each parameter register = slot - 1
  localparam int IDX_FEAT = 0;
  localparam int IDX_CNT  = 1;
  localparam int IDX_LBA0 = 2;
  localparam int IDX_LBA1 = 3;
  localparam int IDX_LBA2 = 4;
  localparam int IDX_DEV  = 5;
endpackage

// File: rtl/tf_rst_sync.sv
module tf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tf_decode.sv
module tf_decode
  import tf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 regs_wr_ok,
  output logic [TF_NREG-1:0]   reg_we,
  output logic                 cmd_we,
  output logic                 ctl_we,
  output logic                 stat_rd,
  output logic                 rd_hit,
  output tf_slot_e             slot
);
  logic hit;
  logic wr_gated;

  generate
    if (ADDR_W > TF_SLOT_W) begin : g_wide
      assign hit = (bus_addr[ADDR_W-1:TF_SLOT_W] == '0);
    end else begin : g_narrow
      assign hit = 1'b1;
    end
  endgenerate

  assign slot     = tf_slot_e'(bus_addr[TF_SLOT_W-1:0]);
  assign wr_gated = bus_wr && regs_wr_ok && hit;

  genvar gi;
  generate
    for (gi = 0; gi < TF_NREG; gi++) begin : g_we
      assign reg_we[gi] = wr_gated && (bus_addr[TF_SLOT_W-1:0] == TF_SLOT_W'(gi + 1));
    end
  endgenerate

  assign cmd_we  = wr_gated && (slot == SLOT_CMD);
  assign ctl_we  = bus_wr && hit && (slot == SLOT_CTL);
  assign stat_rd = bus_rd && hit && (slot == SLOT_CMD);
  assign rd_hit  = bus_rd && hit;
endmodule

// File: rtl/tf_reg_bank.sv
module tf_reg_bank
  import tf_pkg::*;
#(
  parameter int NREG = TF_NREG,
  parameter int W    = TF_BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREG-1:0]       we,
  input  logic [W-1:0]          din,
  output logic [NREG-1:0][W-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_reg
      logic [W-1:0] r_q;
      logic [W-1:0] r_d;

      always_comb begin
        r_d = r_q;
        if (we[gi]) r_d = din;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
      end

      assign q[gi] = r_q;
    end
  endgenerate
endmodule

// File: rtl/tf_irq.sv
module tf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic irq_off,
  output logic pending,
  output logic irq
);
  logic pend_q;
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (set_req)      pend_d = 1'b1;
    else if (clr_req) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;
  assign irq     = pend_q && !irq_off;
endmodule

// File: rtl/drive_taskfile.sv
module drive_taskfile
  import tf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              regs_wr_ok,
  input  logic              irq_req,
  input  logic [7:0]        drv_status,
  input  logic [7:0]        drv_error,
  input  logic [7:0]        disc_info,
  output logic [7:0]        feature_q,
  output logic [7:0]        count_q,
  output logic [7:0]        lba0_q,
  output logic [7:0]        lba1_q,
  output logic [7:0]        lba2_q,
  output logic [7:0]        device_q,
  output logic              cmd_strobe,
  output logic [7:0]        cmd_code,
  output logic              devctl_strobe,
  output logic [7:0]        devctl_value,
  output logic              irq_pending,
  output logic              irq_out
);
  localparam int PAD_W = DATA_W - TF_BYTE_W;

  logic                            rst_q_n;
  logic [TF_NREG-1:0]              reg_we;
  logic                            cmd_we;
  logic                            ctl_we;
  logic                            stat_rd;
  logic                            rd_hit;
  tf_slot_e                        slot;
  logic [TF_NREG-1:0][TF_BYTE_W-1:0] bank_q;
  logic [TF_BYTE_W-1:0]            wbyte;
  logic [TF_BYTE_W-1:0]            rbyte;

  tf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_q_n)
  );

  tf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .regs_wr_ok(regs_wr_ok), .reg_we(reg_we), .cmd_we(cmd_we),
    .ctl_we(ctl_we), .stat_rd(stat_rd), .rd_hit(rd_hit), .slot(slot)
  );

  assign wbyte = bus_wdata[TF_BYTE_W-1:0];

  tf_reg_bank #(.NREG(TF_NREG), .W(TF_BYTE_W)) u_bank (
    .clk(clk), .rst_n(rst_q_n), .we(reg_we), .din(wbyte), .q(bank_q)
  );

  // command and device-control capture
  logic                 cmd_stb_q, cmd_stb_d;
  logic [TF_BYTE_W-1:0] cmd_code_q, cmd_code_d;
  logic                 ctl_stb_q, ctl_stb_d;
  logic [TF_BYTE_W-1:0] ctl_q, ctl_d;

  always_comb begin
    cmd_stb_d  = cmd_we;
    cmd_code_d = cmd_code_q;
    if (cmd_we) cmd_code_d = wbyte;
    ctl_stb_d  = ctl_we;
    ctl_d      = ctl_q;
    if (ctl_we) ctl_d = wbyte;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cmd_stb_q  <= 1'b0;
      cmd_code_q <= '0;
      ctl_stb_q  <= 1'b0;
      ctl_q      <= '0;
    end else begin
      cmd_stb_q  <= cmd_stb_d;
      cmd_code_q <= cmd_code_d;
      ctl_stb_q  <= ctl_stb_d;
      ctl_q      <= ctl_d;
    end
  end

  tf_irq u_irq (
    .clk(clk), .rst_n(rst_q_n),
    .set_req(irq_req), .clr_req(cmd_we || stat_rd),
    .irq_off(ctl_q[TF_IRQ_OFF_BIT]),
    .pending(irq_pending), .irq(irq_out)
  );

  // read-side meaning of each address
  always_comb begin
    rbyte = '0;
    if (rd_hit) begin
      case (slot)
        SLOT_CTL:  rbyte = drv_status;
        SLOT_CMD:  rbyte = drv_status;
        SLOT_FEAT: rbyte = drv_error;
        SLOT_LBA0: rbyte = disc_info;
        SLOT_CNT:  rbyte = bank_q[IDX_CNT];
        SLOT_LBA1: rbyte = bank_q[IDX_LBA1];
        SLOT_LBA2: rbyte = bank_q[IDX_LBA2];
        SLOT_DEV:  rbyte = bank_q[IDX_DEV];
        default:   rbyte = '0;
      endcase
    end
  end

  assign bus_rdata = {{PAD_W{1'b0}}, rbyte};

  assign feature_q     = bank_q[IDX_FEAT];
  assign count_q       = bank_q[IDX_CNT];
  assign lba0_q        = bank_q[IDX_LBA0];
  assign lba1_q        = bank_q[IDX_LBA1];
  assign lba2_q        = bank_q[IDX_LBA2];
  assign device_q      = bank_q[IDX_DEV];
  assign cmd_strobe    = cmd_stb_q;
  assign cmd_code      = cmd_code_q;
  assign devctl_strobe = ctl_stb_q;
  assign devctl_value  = ctl_q;
endmodule

// File: rtl/drive_taskfile_chk.sv
module drive_taskfile_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              regs_wr_ok,
  input logic              irq_req,
  input logic [7:0]        feature_q,
  input logic              cmd_strobe,
  input logic [7:0]        cmd_code,
  input logic              irq_pending,
  input logic              irq_out
);
  logic cmd_hit, stat_hit, alt_hit;
  assign cmd_hit  = bus_wr && regs_wr_ok && (bus_addr == ADDR_W'(7));
  assign stat_hit = bus_rd && (bus_addr == ADDR_W'(7));
  assign alt_hit  = bus_rd && (bus_addr == ADDR_W'(0));

  // R3
  gated_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> $past(cmd_hit));

  // R3
  feat_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !regs_wr_ok && bus_addr == ADDR_W'(1)) |=> $stable(feature_q));

  // R4
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> (cmd_strobe && cmd_code == $past(bus_wdata[7:0])));

  // R7
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_hit && !irq_req) |=> !irq_pending);

  // R8
  alt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_hit && irq_pending && !cmd_hit) |=> irq_pending);

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> irq_pending);

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> irq_pending);
endmodule

bind drive_taskfile drive_taskfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .regs_wr_ok(regs_wr_ok),
  .irq_req(irq_req), .feature_q(feature_q), .cmd_strobe(cmd_strobe),
  .cmd_code(cmd_code), .irq_pending(irq_pending), .irq_out(irq_out)
);

// File: tb/drive_taskfile_tb_top.sv
`timescale 1ns/1ps
module drive_taskfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        regs_wr_ok, irq_req;
  logic [7:0]  drv_status, drv_error, disc_info;
  logic [7:0]  feature_q, count_q, lba0_q, lba1_q, lba2_q, device_q;
  logic        cmd_strobe, devctl_strobe, irq_pending, irq_out;
  logic [7:0]  cmd_code, devctl_value;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  drive_taskfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .regs_wr_ok(regs_wr_ok), .irq_req(irq_req), .drv_status(drv_status),
    .drv_error(drv_error), .disc_info(disc_info), .feature_q(feature_q),
    .count_q(count_q), .lba0_q(lba0_q), .lba1_q(lba1_q), .lba2_q(lba2_q),
    .device_q(device_q), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
    .devctl_strobe(devctl_strobe), .devctl_value(devctl_value),
    .irq_pending(irq_pending), .irq_out(irq_out)
  );

  // reference model state
  int  m_reg [6];
  int  m_cmd_code, m_ctl;
  bit  m_cmd_stb, m_ctl_stb, m_pend;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rdata(input bit rd, input int a);
    if (!rd) return 0;
    case (a)
      0, 7: return int'(drv_status);
      1: return int'(drv_error);
      3: return int'(disc_info);
      2: return m_reg[1];
      4: return m_reg[3];
      5: return m_reg[4];
      6: return m_reg[5];
      default: return 0;
    endcase
  endfunction

  task automatic check_state(input string when);
    check(feature_q == 8'(m_reg[0]), {"R2 R3 feature ", when}, feature_q, m_reg[0]);
    check(count_q   == 8'(m_reg[1]), {"R2 R3 count ", when},   count_q,   m_reg[1]);
    check(lba0_q    == 8'(m_reg[2]), {"R2 R3 lba0 ", when},    lba0_q,    m_reg[2]);
    check(lba1_q    == 8'(m_reg[3]), {"R2 R3 lba1 ", when},    lba1_q,    m_reg[3]);
    check(lba2_q    == 8'(m_reg[4]), {"R2 R3 lba2 ", when},    lba2_q,    m_reg[4]);
    check(device_q  == 8'(m_reg[5]), {"R2 R3 device ", when},  device_q,  m_reg[5]);
    check(cmd_strobe == m_cmd_stb, {"R4 cmd strobe ", when}, cmd_strobe, m_cmd_stb);
    check(cmd_code == 8'(m_cmd_code), {"R4 cmd code ", when}, cmd_code, m_cmd_code);
    check(devctl_strobe == m_ctl_stb, {"R9 devctl strobe ", when}, devctl_strobe, m_ctl_stb);
    check(devctl_value == 8'(m_ctl), {"R9 devctl value ", when}, devctl_value, m_ctl);
    check(irq_pending == m_pend, {"R5 R7 R8 R11 pending ", when}, irq_pending, m_pend);
    check(irq_out == (m_pend && !m_ctl[1]), {"R12 irq out ", when}, irq_out, m_pend && !m_ctl[1]);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input bit wr, input bit rd, input int a, input int d,
                     input bit ok, input bit irq);
    int er;
    bit clr;
    bus_wr = wr; bus_rd = rd; bus_addr = 4'(a); bus_wdata = 32'(d);
    regs_wr_ok = ok; irq_req = irq;
    #1;
    er = exp_rdata(rd, a);
    check(bus_rdata == 32'(er),
          (a == 1) ? "R6 read error" : (a == 7) ? "R7 read status" :
          (a == 0) ? "R8 read alt status" : "R10 read back",
          bus_rdata, er);
    @(posedge clk);
    m_cmd_stb = wr && ok && a == 7;
    m_ctl_stb = wr && a == 0;
    if (wr && ok && a >= 1 && a <= 6) m_reg[a-1] = d & 8'hFF;
    if (m_cmd_stb) m_cmd_code = d & 8'hFF;
    if (m_ctl_stb) m_ctl = d & 8'hFF;
    clr = m_cmd_stb || (rd && a == 7);
    if (irq) m_pend = 1'b1;
    else if (clr) m_pend = 1'b0;
    @(negedge clk);
    check_state("after cycle");
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    regs_wr_ok = 0; irq_req = 0;
    drv_status = 8'h50; drv_error = 8'h04; disc_info = 8'h2C;
    foreach (m_reg[i]) m_reg[i] = 0;
    m_cmd_code = 0; m_ctl = 0; m_cmd_stb = 0; m_ctl_stb = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    check_state("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_state("R1 after reset");

    // R2: low-byte capture with junk upper bits
    for (int i = 1; i <= 6; i++) cyc(1, 0, i, 32'hA5A5_0010 + i, 1, 0);
    // R10 readback, R6 error, disc info
    for (int i = 0; i <= 15; i++) cyc(0, 1, i, 0, 0, 0);
    cyc(0, 0, 2, 0, 0, 0);              // R10 rd low returns zero
    // R3: locked writes
    for (int i = 1; i <= 7; i++) cyc(1, 0, i, 32'hFF, 0, 0);
    cyc(1, 0, 9, 32'h77, 1, 0);         // R3 unmapped
    cyc(1, 0, 10, 32'h77, 1, 0);
    // R11 set, R8 alt read keeps, R7 status read clears
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 1, 7, 0, 0, 0);
    // R11 set wins over status read
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 1, 7, 0, 0, 1);
    // R3 locked command does not clear; R5 accepted command clears
    cyc(1, 0, 7, 32'h1234_00A0, 0, 0);
    cyc(1, 0, 7, 32'h1234_00A0, 1, 0);
    cyc(1, 0, 7, 32'h0000_00EC, 1, 0);  // R4 back-to-back commands
    idle();
    // R9 device control while locked; R12 masking
    cyc(0, 0, 0, 0, 0, 1);
    cyc(1, 0, 0, 32'hFFFF_FF02, 0, 0);
    idle();
    cyc(1, 0, 0, 32'h0000_0000, 1, 0);
    idle();
    // random run
    for (int k = 0; k < 600; k++) begin
      int r;
      r = $urandom;
      drv_status = 8'($urandom); drv_error = 8'($urandom); disc_info = 8'($urandom);
      cyc(r[0], r[1], int'(r[7:4]) & ((r[3]) ? 15 : 7), $urandom, r[2], r[8] & r[9]);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule